// File: doc/BRIEF.md
# Asynchronous NOR Memory Timing Sequencer

This block drives one external asynchronous NOR flash bank on a bus where address and data are not multiplexed. A host issues single read or write requests through a request/ready handshake. The block turns each request into chip-select, output-enable and write-enable waveforms and returns a one-cycle completion pulse. On reads, that pulse carries the captured data.

Each access has up to four phases: an address phase, a data phase, a hold phase and a turnaround gap. Two 32-bit timing words set the length of each phase. The general word always sets read timing. When the general word selects extended mode, writes take their timing from the write word. The bank-enable input gates every access. A request made while the bank is disabled is refused with an error and causes no bus activity.

Top module: `nor_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dout_en` and `done` are low, and `ready` is high.
- R2: A request is accepted on a rising edge where `req` and `ready` are both high. Chip select then goes low for an address phase lasting timing bits [3:0] cycles. A value of 0 skips the phase, so the data phase starts in the first cycle.
- R3: The data phase lasts timing bits [15:8] cycles, and a value of 0 is treated as 1. During the data phase of a read, `mem_oe_n` is low and `mem_we_n` is high.
- R4: The hold phase keeps chip select low with both strobes high. It lasts timing bits [31:30] cycles on a read and that value plus one on a write.
- R5: Once chip select rises, it stays high for timing bits [19:16] cycles, and `ready` stays low through that gap. `ready` is also low in the cycle where `done` is high.
- R6: Writes use `tim_wr` only when `tim_gen` bits [29:28] equal 1 (extended mode). In every other case, writes use `tim_gen`. Reads always use `tim_gen`.
- R7: `done` is high for exactly one cycle, namely the first cycle after chip select rises. On a read, `rdata` then holds the `mem_din` value from the last data-phase cycle.
- R8: During a write, `mem_we_n` is low exactly for the data phase. `mem_dout_en` is high, and `mem_dout`/`mem_addr` carry the request's data and address, through every cycle in which chip select is low.
- R9: A request made while `bank_en` is low is answered with `done` and `err` high in the next cycle, and chip select stays high.
- R10: Chip select is low without a break from the first phase through the end of the hold phase. `mem_oe_n` and `mem_we_n` are never low at the same time, and neither is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | Bank enable; accesses are accepted only when high |
| tim_gen | input | 32 | General timing word |
| tim_wr | input | 32 | Write timing word, used in extended mode |
| req | input | 1 | Access request, qualified by `ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ready | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Qualifies `done`: request refused because the bank is disabled |
| rdata | output | DW | Read data captured during the last data cycle |
| mem_addr | output | AW | Address to the memory |
| mem_dout | output | DW | Write data to the memory |
| mem_dout_en | output | 1 | Output enable for the data pins |
| mem_din | input | DW | Read data from the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench drives accesses with zero-length address, data, hold and turnaround fields, and also with the largest values. A design that mishandles zero would stall or add an extra phase, and the per-cycle comparison of the strobes would show the shift. Reads and writes are made to use different timing words under both mode settings. A design that ignores the mode field, or applies the write word to reads, produces a data phase of the wrong length. The memory read value changes every cycle, so capturing one cycle early or late gives the wrong `rdata`. Write hold length, the disabled-bank refusal and back-to-back issue at the first ready cycle are each checked, so an off-by-one in the hold or turnaround counts shows up.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_HOLD,
        PH_TURN
    } phase_e;

    // raw fields of one timing word
    typedef struct packed {
        logic [1:0] hold;
        logic [1:0] mode;
        logic [3:0] turn;
        logic [7:0] datast;
        logic [3:0] addset;
    } tim_s;

    // resolved phase lengths for one access
    typedef struct packed {
        logic [3:0] addr_cyc;
        logic [7:0] data_cyc;
        logic [2:0] hold_cyc;
        logic [3:0] turn_cyc;
    } lens_s;

    localparam logic [1:0] MODE_EXT = 2'd1;

    function automatic tim_s decode_tim(input logic [31:0] r);
        tim_s t;
        t.hold   = r[31:30];
        t.mode   = r[29:28];
        t.turn   = r[19:16];
        t.datast = r[15:8];
        t.addset = r[3:0];
        return t;
    endfunction

endpackage

// File: rtl/nor_seq_tsel.sv
module nor_seq_tsel
    import nor_seq_pkg::*;
(
    input  logic [31:0] gen_tim,
    input  logic [31:0] wr_tim,
    input  logic        is_write,
    output lens_s       lens
);
    tim_s g, w, s;
    logic unused_bits;
    assign unused_bits = ^{gen_tim[27:20], gen_tim[7:4], wr_tim[29:20], wr_tim[7:4]};

    always_comb begin
        g = decode_tim(gen_tim);
        w = decode_tim(wr_tim);
        s = (is_write && g.mode == MODE_EXT) ? w : g;
        lens.addr_cyc = s.addset;
        lens.data_cyc = (s.datast == 8'd0) ? 8'd1 : s.datast;
        lens.hold_cyc = {1'b0, s.hold} + {2'b00, is_write};
        lens.turn_cyc = s.turn;
    end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  lens_s  lens_in,
    output phase_e phase,
    output logic   last_data,
    output logic   release_cs
);
    localparam int CW = 8;

    lens_s         lens_q;
    logic [CW-1:0] cnt;
    logic          cnt_zero;

    assign cnt_zero   = (cnt == '0);
    assign last_data  = (phase == PH_DATA) && cnt_zero;
    assign release_cs = (last_data && lens_q.hold_cyc == 3'd0) ||
                        ((phase == PH_HOLD) && cnt_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            lens_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    lens_q <= lens_in;
                    if (lens_in.addr_cyc != 4'd0) begin
                        phase <= PH_ADDR;
                        cnt   <= CW'(lens_in.addr_cyc) - 1'b1;
                    end else begin
                        phase <= PH_DATA;
                        cnt   <= lens_in.data_cyc - 1'b1;
                    end
                end
                PH_ADDR: if (cnt_zero) begin
                    phase <= PH_DATA;
                    cnt   <= lens_q.data_cyc - 1'b1;
                end else cnt <= cnt - 1'b1;
                PH_DATA, PH_HOLD: if (release_cs) begin
                    if (lens_q.turn_cyc != 4'd0) begin
                        phase <= PH_TURN;
                        cnt   <= CW'(lens_q.turn_cyc) - 1'b1;
                    end else phase <= PH_IDLE;
                end else if (last_data) begin
                    phase <= PH_HOLD;
                    cnt   <= CW'(lens_q.hold_cyc) - 1'b1;
                end else cnt <= cnt - 1'b1;
                PH_TURN: if (cnt_zero) phase <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nor_seq.sv
module nor_seq
    import nor_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_en,
    input  logic [31:0]   tim_gen,
    input  logic [31:0]   tim_wr,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);
    lens_s  lens;
    phase_e phase;
    logic   last_data, release_cs, accept, start, active, we_q;

    assign ready  = (phase == PH_IDLE) && !done;
    assign accept = req && ready;
    assign start  = accept && bank_en;
    assign active = (phase == PH_ADDR) || (phase == PH_DATA) || (phase == PH_HOLD);

    nor_seq_tsel u_tsel (
        .gen_tim (tim_gen),
        .wr_tim  (tim_wr),
        .is_write(req_we),
        .lens    (lens)
    );

    nor_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .lens_in   (lens),
        .phase     (phase),
        .last_data (last_data),
        .release_cs(release_cs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b0;
            mem_addr <= '0;
            mem_dout <= '0;
            rdata    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (start) begin
                we_q     <= req_we;
                mem_addr <= req_addr;
                mem_dout <= req_wdata;
            end
            if (last_data && !we_q) rdata <= mem_din;
            done <= release_cs || (accept && !bank_en);
            err  <= accept && !bank_en;
        end
    end

    assign mem_cs_n    = !active;
    assign mem_oe_n    = !((phase == PH_DATA) && !we_q);
    assign mem_we_n    = !((phase == PH_DATA) && we_q);
    assign mem_dout_en = active && we_q;
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk (
    input logic clk,
    input logic rst,
    input logic done,
    input logic err,
    input logic ready,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dout_en
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));
    // R10
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_oe_n && mem_we_n));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    done_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (done && !err));
    // R9
    err_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> mem_cs_n);
    // R8
    we_drives_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dout_en);
    // R5
    ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready);
endmodule

bind nor_seq nor_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .err        (err),
    .ready      (ready),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout_en(mem_dout_en)
);

// File: tb/nor_seq_bench.sv
`timescale 1ns/1ps
module nor_seq_bench;
    localparam int AW = 20;
    localparam int DW = 16;

    logic clk = 1'b0, rst = 1'b1, bank_en = 1'b1;
    logic [31:0] tim_gen = '0, tim_wr = '0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, done, err, mem_dout_en, mem_cs_n, mem_oe_n, mem_we_n;
    logic [DW-1:0] rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic [15:0] cyc = '0;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 16'd1;
    assign mem_din = cyc ^ 16'h5A3C;   // changes every cycle

    nor_seq #(.AW(AW), .DW(DW)) u_nor_seq (
        .clk(clk), .rst(rst), .bank_en(bank_en), .tim_gen(tim_gen), .tim_wr(tim_wr),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .err(err), .rdata(rdata), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", rq, cyc, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int a, int d, int t, int m, int h);
        return {h[1:0], m[1:0], 8'h00, t[3:0], d[7:0], 4'h0, a[3:0]};
    endfunction

    // one access, modelled cycle by cycle and compared on every clock
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [31:0] g, input logic [31:0] w, input bit en);
        logic [31:0] s;
        int na, nd, nh, nt, last;
        logic [DW-1:0] exp_rd = '0;
        s  = (we && g[29:28] == 2'd1) ? w : g;
        na = int'(s[3:0]);
        nd = (s[15:8] == 0) ? 1 : int'(s[15:8]);
        nh = int'(s[31:30]) + (we ? 1 : 0);
        nt = int'(s[19:16]);
        tim_gen = g; tim_wr = w; bank_en = en;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        chk(ready === 1'b1, "R2 ready before request", {31'd0, ready}, 1);
        @(posedge clk);
        if (!en) begin
            @(negedge clk);
            req = 1'b0;
            chk(done === 1'b1 && err === 1'b1, "R9 refused done/err", {30'd0, done, err}, 3);
            chk(mem_cs_n === 1'b1, "R9 no chip select", {31'd0, mem_cs_n}, 1);
            @(negedge clk);
            chk(done === 1'b0 && ready === 1'b1 && mem_cs_n === 1'b1, "R9 back to idle",
                {29'd0, done, ready, mem_cs_n}, 3);
            return;
        end
        last = na + nd + nh + ((nt > 0) ? nt : 1);
        for (int k = 0; k <= last; k++) begin
            bit in_a, in_d, in_h, cs;
            @(negedge clk);
            req = 1'b0;
            in_a = (k < na);
            in_d = (k >= na) && (k < na + nd);
            in_h = (k >= na + nd) && (k < na + nd + nh);
            cs   = in_a || in_d || in_h;
            chk(mem_cs_n === !cs, cs ? "R10 chip select low" : "R5 chip select high",
                {31'd0, mem_cs_n}, {31'd0, !cs});
            chk(mem_oe_n === !(in_d && !we), "R3 output enable", {31'd0, mem_oe_n}, {31'd0, !(in_d && !we)});
            chk(mem_we_n === !(in_d && we), "R8 write enable", {31'd0, mem_we_n}, {31'd0, !(in_d && we)});
            chk(done === (k == na + nd + nh), "R7 done pulse", {31'd0, done}, {31'd0, k == na + nd + nh});
            chk(ready === (k == last), "R5 ready", {31'd0, ready}, {31'd0, k == last});
            if (we && cs) begin
                chk(mem_dout_en === 1'b1 && mem_dout === wd && mem_addr === a, "R8 write drive",
                    {mem_dout_en, 15'd0, mem_dout}, {1'b1, 15'd0, wd});
            end
            if (!we && cs) chk(mem_addr === a, "R2 address", {12'd0, mem_addr}, {12'd0, a});
            if (!we && k == na + nd - 1) exp_rd = mem_din;
            if (!we && k == na + nd + nh) chk(rdata === exp_rd, "R7 read data", {16'd0, rdata}, {16'd0, exp_rd});
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk(mem_cs_n === 1 && mem_oe_n === 1 && mem_we_n === 1, "R1 strobes idle",
            {29'd0, mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(done === 0 && mem_dout_en === 0 && ready === 1, "R1 status idle",
            {29'd0, done, mem_dout_en, ready}, 1);
        // R2 R3 R4 R5 R7: read with all phases
        access(0, 20'h01234, '0, mk(2, 3, 2, 0, 1), mk(9, 9, 9, 0, 3), 1);
        // R2 R3: zero fields, back-to-back issue
        access(0, 20'h00F0F, '0, mk(0, 0, 0, 0, 0), '0, 1);
        // R4 R6: write without extended mode, write word ignored
        access(1, 20'hABCDE, 16'hBEEF, mk(1, 2, 1, 0, 0), mk(7, 9, 5, 1, 3), 1);
        // R6: extended-mode write takes the write word
        access(1, 20'h11111, 16'h1357, mk(3, 6, 2, 1, 2), mk(0, 1, 0, 1, 3), 1);
        // R6: extended-mode read still uses general word
        access(0, 20'h22222, '0, mk(1, 4, 1, 1, 2), mk(5, 1, 0, 1, 0), 1);
        // R9: disabled bank
        access(0, 20'h33333, '0, mk(1, 1, 1, 0, 0), '0, 0);
        access(1, 20'h44444, 16'hCAFE, mk(1, 1, 1, 0, 0), '0, 0);
        // R2 R4 R5 R8: largest fields
        access(1, 20'hFFFFF, 16'hA5A5, mk(15, 255, 15, 0, 3), '0, 1);
        access(0, 20'h55555, '0, mk(15, 255, 15, 0, 3), '0, 1);
        finished = 1;
        report();
    end
endmodule